// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block generates the row timing for a multiplexed dot-matrix panel driven through up to sixteen common electrodes. It runs from the display oscillator clock and takes two mode bits from the command logic: whether the panel has two text lines, and whether the single-line font is the tall (ten-row) one. From these it picks how many commons are scanned per frame and how many clocks each common stays active. It then steps a row counter, asserts exactly one common select, and pulses a latch strobe so the segment path loads the pattern for the new row.

Alongside the scan it produces the AC polarity bit that alternates the drive waveform, either once per frame or once per row depending on a waveform-style strap. It also reports whether the bias network must divide by five or by four, and maps the logical commons onto physical pins for either chip orientation, with a flag that tells the segment path to reverse its column order. Mode changes requested mid-frame are held off until the current frame is finished, so a frame is never cut short or stretched.

Top module: `lcd_com_scan`

## Requirements
- R1: The number of rows per frame is 16 when `two_line` is 1 (whatever `tall_font` is), 11 when `two_line` is 0 and `tall_font` is 1, and 8 when both are 0; `row_idx` steps 0, 1, ... up to rows-1 and then returns to 0.
- R2: Each row lasts `ROW_CLKS_LONG` clocks in the 8-row and 11-row modes and `ROW_CLKS_SHORT` clocks in the 16-row mode, so a frame lasts rows times that count.
- R3: `seg_latch` is high for exactly one clock, the first clock of every row; `row_idx` already shows the new row on that clock and holds it until the next strobe.
- R4: `com_sel` is one-hot; with `orient` = 1 bit r is set for row r, with `orient` = 0 bit (r + 8) mod 16 is set for row r (the two halves swap).
- R5: `seg_reverse` is 1 when `orient` is 0 and 0 when `orient` is 1.
- R6: `bias_fifth` is 1 exactly while the 16-row mode is in effect and 0 in the 8-row and 11-row modes.
- R7: With `wave_b` = 0, `ac_pol` inverts once at the start of each frame (on the strobe of row 0) and stays constant for the rest of the frame.
- R8: With `wave_b` = 1, `ac_pol` inverts on the strobe of every row.
- R9: A change of `two_line` or `tall_font` during a frame does not alter the current frame; it takes effect on the next return to row 0, which also updates `bias_fifth`.
- R10: Reset sets row 0 at its first clock, the 8-row mode, `ac_pol` 0 and `seg_latch` 1; the first frame after reset therefore runs in 8-row mode and the mode inputs are first applied at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_line | input | 1 | Two text lines selected (16-row scan) |
| tall_font | input | 1 | Ten-row font selected for single-line use |
| wave_b | input | 1 | Polarity style: 0 invert per frame, 1 invert per row |
| orient | input | 1 | Chip orientation: 1 natural pin order, 0 mirrored |
| com_sel | output | COM_LINES | One-hot physical common select |
| row_idx | output | ROW_W | Logical row being scanned, for pattern fetch |
| seg_latch | output | 1 | One-clock strobe at the first clock of each row |
| ac_pol | output | 1 | Drive waveform polarity |
| bias_fifth | output | 1 | 1: one-fifth bias, 0: one-quarter bias |
| seg_reverse | output | 1 | Segment column order must be reversed |

## Verification
Every timed result comes from one register stage: the clock edge that ends a row is the edge after which `seg_latch`, `row_idx`, `com_sel`, `ac_pol` and, at a frame end, `bias_fifth` all show their new values together, so they are due one clock after the last clock of the row. The bench drives inputs and samples outputs on the falling edge, counts falling edges between two row-0 strobes to get the frame length, and reads the row, select and polarity on each strobe cycle. A mode change is applied on a falling edge and is only expected after the next row-0 strobe, so the frame in progress is measured under the old mode.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        DUTY_SHORT = 2'd0,
        DUTY_TALL  = 2'd1,
        DUTY_DUAL  = 2'd2
    } duty_e;

    // Two lines always use the full scan; font only matters for one line.
    function automatic duty_e pick_duty(input logic two_line, input logic tall_font);
        if (two_line) begin
            return DUTY_DUAL;
        end
        if (tall_font) begin
            return DUTY_TALL;
        end
        return DUTY_SHORT;
    endfunction

endpackage

// File: rtl/lcd_duty_decode.sv
module lcd_duty_decode
    import lcd_scan_pkg::*;
#(
    parameter int ROWS_SHORT     = 8,
    parameter int ROWS_TALL      = 11,
    parameter int ROWS_DUAL      = 16,
    parameter int ROW_CLKS_LONG  = 800,
    parameter int ROW_CLKS_SHORT = 400,
    parameter int ROW_W          = 4,
    parameter int TICK_W         = 10
) (
    input  duty_e              duty,
    output logic [ROW_W-1:0]   row_last,
    output logic [TICK_W-1:0]  tick_last,
    output logic               bias_fifth
);

    localparam logic [ROW_W-1:0]  LAST_SHORT = ROW_W'(ROWS_SHORT - 1);
    localparam logic [ROW_W-1:0]  LAST_TALL  = ROW_W'(ROWS_TALL - 1);
    localparam logic [ROW_W-1:0]  LAST_DUAL  = ROW_W'(ROWS_DUAL - 1);
    localparam logic [TICK_W-1:0] TICK_LONG  = TICK_W'(ROW_CLKS_LONG - 1);
    localparam logic [TICK_W-1:0] TICK_SHORT = TICK_W'(ROW_CLKS_SHORT - 1);

    always_comb begin
        case (duty)
            DUTY_TALL: begin
                row_last   = LAST_TALL;
                tick_last  = TICK_LONG;
                bias_fifth = 1'b0;
            end
            DUTY_DUAL: begin
                row_last   = LAST_DUAL;
                tick_last  = TICK_SHORT;
                bias_fifth = 1'b1;
            end
            default: begin
                row_last   = LAST_SHORT;
                tick_last  = TICK_LONG;
                bias_fifth = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
    import lcd_scan_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  duty_e             duty_req,
    input  logic              wave_b,
    input  logic [ROW_W-1:0]  row_last,
    input  logic [TICK_W-1:0] tick_last,
    output duty_e             duty,
    output logic [ROW_W-1:0]  row,
    output logic              strobe,
    output logic              pol
);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [ROW_W-1:0]  row;
        duty_e             duty;
        logic              pol;
        logic              strobe;
    } timer_t;

    timer_t st_d, st_q;
    logic   row_end, frame_end;

    always_comb begin
        st_d      = st_q;
        row_end   = (st_q.tick == tick_last);
        frame_end = row_end && (st_q.row == row_last);

        if (row_end) begin
            st_d.tick   = '0;
            st_d.strobe = 1'b1;
            if (wave_b) begin
                st_d.pol = ~st_q.pol;
            end
            if (frame_end) begin
                st_d.row  = '0;
                st_d.duty = duty_req;
                if (!wave_b) begin
                    st_d.pol = ~st_q.pol;
                end
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end else begin
            st_d.tick   = st_q.tick + 1'b1;
            st_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tick   <= '0;
            st_q.row    <= '0;
            st_q.duty   <= DUTY_SHORT;
            st_q.pol    <= 1'b0;
            st_q.strobe <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty   = st_q.duty;
    assign row    = st_q.row;
    assign strobe = st_q.strobe;
    assign pol    = st_q.pol;

endmodule

// File: rtl/lcd_com_mapper.sv
module lcd_com_mapper #(
    parameter int COM_LINES = 16,
    parameter int ROW_W     = 4
) (
    input  logic [ROW_W-1:0]     row,
    input  logic                 orient,
    output logic [COM_LINES-1:0] com_sel
);

    localparam int HALF = COM_LINES / 2;

    for (genvar p = 0; p < COM_LINES; p++) begin : g_pin
        localparam int SWAPPED = (p + HALF) % COM_LINES;
        assign com_sel[p] = orient ? (row == ROW_W'(p)) : (row == ROW_W'(SWAPPED));
    end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
    import lcd_scan_pkg::*;
#(
    parameter int COM_LINES      = 16,
    parameter int ROWS_SHORT     = 8,
    parameter int ROWS_TALL      = 11,
    parameter int ROW_CLKS_LONG  = 800,
    parameter int ROW_CLKS_SHORT = 400,
    localparam int ROW_W         = $clog2(COM_LINES),
    localparam int TICK_W        = $clog2(ROW_CLKS_LONG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 two_line,
    input  logic                 tall_font,
    input  logic                 wave_b,
    input  logic                 orient,
    output logic [COM_LINES-1:0] com_sel,
    output logic [ROW_W-1:0]     row_idx,
    output logic                 seg_latch,
    output logic                 ac_pol,
    output logic                 bias_fifth,
    output logic                 seg_reverse
);

    duty_e              duty_req;
    duty_e              duty_cur;
    logic [ROW_W-1:0]   row_last;
    logic [TICK_W-1:0]  tick_last;

    assign duty_req = pick_duty(two_line, tall_font);

    lcd_duty_decode #(
        .ROWS_SHORT     (ROWS_SHORT),
        .ROWS_TALL      (ROWS_TALL),
        .ROWS_DUAL      (COM_LINES),
        .ROW_CLKS_LONG  (ROW_CLKS_LONG),
        .ROW_CLKS_SHORT (ROW_CLKS_SHORT),
        .ROW_W          (ROW_W),
        .TICK_W         (TICK_W)
    ) i_decode (
        .duty       (duty_cur),
        .row_last   (row_last),
        .tick_last  (tick_last),
        .bias_fifth (bias_fifth)
    );

    lcd_row_timer #(
        .ROW_W  (ROW_W),
        .TICK_W (TICK_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_req  (duty_req),
        .wave_b    (wave_b),
        .row_last  (row_last),
        .tick_last (tick_last),
        .duty      (duty_cur),
        .row       (row_idx),
        .strobe    (seg_latch),
        .pol       (ac_pol)
    );

    lcd_com_mapper #(
        .COM_LINES (COM_LINES),
        .ROW_W     (ROW_W)
    ) i_mapper (
        .row     (row_idx),
        .orient  (orient),
        .com_sel (com_sel)
    );

    assign seg_reverse = ~orient;

endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
    parameter int COM_LINES = 16,
    parameter int ROWS_TALL = 11,
    parameter int ROW_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wave_b,
    input logic [COM_LINES-1:0] com_sel,
    input logic [ROW_W-1:0]     row_idx,
    input logic                 seg_latch,
    input logic                 ac_pol,
    input logic                 bias_fifth
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_onehot_com_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(com_sel) == 1);

    assert_latch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_latch |=> !seg_latch);

    assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !seg_latch) |-> $stable(row_idx));

    assert_row_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && seg_latch) |-> (row_idx == '0 || row_idx == ($past(row_idx) + 1'b1)));

    assert_bias_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(row_idx) >= ROWS_TALL) |-> bias_fifth);

    assert_pol_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && seg_latch && $past(wave_b)) |-> (ac_pol != $past(ac_pol)));

    assert_pol_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && seg_latch && !$past(wave_b) && row_idx != '0) |-> $stable(ac_pol));

    assert_pol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !seg_latch) |-> $stable(ac_pol));

endmodule

bind lcd_com_scan lcd_com_scan_chk #(
    .COM_LINES (COM_LINES),
    .ROWS_TALL (ROWS_TALL),
    .ROW_W     (ROW_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wave_b     (wave_b),
    .com_sel    (com_sel),
    .row_idx    (row_idx),
    .seg_latch  (seg_latch),
    .ac_pol     (ac_pol),
    .bias_fifth (bias_fifth)
);

// File: tb/test_lcd_com_scan.sv
`timescale 1ns/1ps
module test_lcd_com_scan;

    localparam int LONG  = 10;
    localparam int SHORT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        two_line = 1'b0;
    logic        tall_font = 1'b0;
    logic        wave_b = 1'b0;
    logic        orient = 1'b1;
    logic [15:0] com_sel;
    logic [3:0]  row_idx;
    logic        seg_latch;
    logic        ac_pol;
    logic        bias_fifth;
    logic        seg_reverse;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    lcd_com_scan #(
        .ROW_CLKS_LONG  (LONG),
        .ROW_CLKS_SHORT (SHORT)
    ) i_lcd_com_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .two_line    (two_line),
        .tall_font   (tall_font),
        .wave_b      (wave_b),
        .orient      (orient),
        .com_sel     (com_sel),
        .row_idx     (row_idx),
        .seg_latch   (seg_latch),
        .ac_pol      (ac_pol),
        .bias_fifth  (bias_fifth),
        .seg_reverse (seg_reverse)
    );

    // {two_line, tall_font, wave_b, orient, rows[4:0], frame_len[6:0], bias}
    localparam int NVEC = 7;
    localparam logic [16:0] VEC [NVEC] = '{
        {4'b0001, 5'd8,  7'd80,  1'b0},
        {4'b0101, 5'd11, 7'd110, 1'b0},
        {4'b1001, 5'd16, 7'd80,  1'b1},
        {4'b1110, 5'd16, 7'd80,  1'b1},
        {4'b0010, 5'd8,  7'd80,  1'b0},
        {4'b0111, 5'd11, 7'd110, 1'b0},
        {4'b0000, 5'd8,  7'd80,  1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_sel(input int r, input logic ori);
        int b;
        b = ori ? r : (r + 8) % 16;
        return 16'(1) << b;
    endfunction

    task automatic wait_frame_start();
        do @(negedge clk); while (!(seg_latch && row_idx == 4'd0));
    endtask

    // Called on the negedge that shows a row-0 strobe; returns on the next one.
    task automatic measure_frame(input int rows, input int len, input logic bias,
                                 input logic wv, input logic ori);
        logic p0, prev;
        int   strobes, cnt;
        chk(row_idx == 4'd0, "R1 frame starts at row 0", row_idx, 0);
        chk(bias_fifth == bias, "R6 bias select", bias_fifth, bias);
        chk(com_sel == exp_sel(0, ori), "R4 select row 0", com_sel, exp_sel(0, ori));
        chk(seg_reverse == ~ori, "R5 segment reverse", seg_reverse, ~ori);
        p0 = ac_pol;
        prev = ac_pol;
        strobes = 1;
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (seg_latch) begin
                if (row_idx == 4'd0) break;
                chk(int'(row_idx) == strobes, "R1 row step", row_idx, strobes);
                chk(com_sel == exp_sel(strobes, ori), "R4 one-hot select", com_sel,
                    exp_sel(strobes, ori));
                if (wv) chk(ac_pol == ~prev, "R8 per-row inversion", ac_pol, ~prev);
                else    chk(ac_pol == prev, "R7 constant within frame", ac_pol, prev);
                prev = ac_pol;
                strobes++;
            end else if (cnt > 200) begin
                break;
            end
        end
        chk(cnt == len, "R2 frame length", cnt, len);
        chk(strobes == rows, "R3 strobes per frame", strobes, rows);
        if (wv) chk(ac_pol == ~prev, "R8 inversion at frame start", ac_pol, ~prev);
        else    chk(ac_pol == ~p0, "R7 inversion per frame", ac_pol, ~p0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R10 watchdog: actual 0 expected 1 finished run");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R10: reset state, two-line request pending during reset
        two_line = 1'b1;
        repeat (3) @(negedge clk);
        chk(row_idx == 4'd0, "R10 reset row", row_idx, 0);
        chk(com_sel == 16'h0001, "R10 reset select", com_sel, 1);
        chk(seg_latch == 1'b1, "R10 reset strobe", seg_latch, 1);
        chk(ac_pol == 1'b0, "R10 reset polarity", ac_pol, 0);
        chk(bias_fifth == 1'b0, "R10 reset bias", bias_fifth, 0);
        rst_n = 1'b1;
        // First frame still 8 rows, request applied at its end.
        measure_frame(8, 80, 1'b0, 1'b0, 1'b1);
        measure_frame(16, 80, 1'b1, 1'b0, 1'b1);

        // Table-driven mode sweep
        for (int v = 0; v < NVEC; v++) begin
            two_line  = VEC[v][16];
            tall_font = VEC[v][15];
            wave_b    = VEC[v][14];
            orient    = VEC[v][13];
            wait_frame_start();
            measure_frame(int'(VEC[v][12:8]), int'(VEC[v][7:1]), VEC[v][0],
                          VEC[v][14], VEC[v][13]);
        end

        // R9: mid-frame mode change waits for frame end
        two_line = 1'b0; tall_font = 1'b0; wave_b = 1'b0; orient = 1'b1;
        wait_frame_start();
        do @(negedge clk); while (!(seg_latch && row_idx == 4'd3));
        two_line = 1'b1;
        forever begin
            @(negedge clk);
            if (seg_latch) begin
                if (row_idx == 4'd0 || row_idx > 4'd7) break;
                chk(bias_fifth == 1'b0, "R9 old mode kept mid-frame", bias_fifth, 0);
            end
        end
        chk(row_idx == 4'd0, "R9 wrap after row 7", row_idx, 0);
        chk(bias_fifth == 1'b1, "R9 new mode at frame start", bias_fifth, 1);
        measure_frame(16, 80, 1'b1, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule